// File: doc/BRIEF.md
# Self-Clocking Biphase Line Receiver with Rate Learning

This block turns an oversampled biphase (Manchester) line back into bytes without being told the bit rate beforehand. It runs on a fast system clock, passes the line through a two-stage synchronizer, and counts how many clock cycles each constant-level pulse lasts between line transitions.

Each packet opens with a sync header: a high pulse one and a half bits long, then a low pulse half a bit long. The receiver records the width of the long high pulse and takes half of it, which is three quarters of a bit, as its threshold. Every later pulse narrower than the threshold is a half-bit pulse, and every pulse at least as wide is a full-bit pulse. From that split the receiver follows which transitions fall in the middle of a bit, decodes each mid-bit transition into a bit, and assembles the bits into bytes. A packet ends when the line stays quiet for too long. A pulse wider than the header aborts the packet.

Top module: `manch_rx`

## Requirements
- R1: After reset, `byte_valid_o`, `done_o` and `frame_err_o` are low and `byte_o` is zero.
- R2: Decoding starts only after a header: a high pulse wider than `MIN_HDR` cycles, then a low pulse narrower than half the high pulse width. If the high pulse is not wider than `MIN_HDR`, or if the low pulse reaches the threshold, the receiver keeps searching and produces no bytes.
- R3: The threshold is the header high width shifted right by one. A data pulse narrower than the threshold is a half-bit pulse. A data pulse at or above the threshold is a full-bit pulse. This holds at the exact boundary, for example a threshold of 9 with half pulses of 8 cycles and full pulses of 9 cycles.
- R4: A bit of value 1 is sent low for its first half and high for its second half. A rising mid-bit transition decodes as 1 and a falling one decodes as 0. The rising transition that ends the header counts as a mid-bit transition.
- R5: Bits are shifted in most significant first. After eight bits the byte appears on `byte_o`, and `byte_valid_o` is high for exactly one cycle.
- R6: No rate setting exists. Packets at different bit rates, each with its own header, decode correctly one after another.
- R7: During decoding, if the line shows no transition for twice the header high width, `done_o` pulses for one cycle and the receiver returns to searching. Before that many cycles have passed, `done_o` stays low.
- R8: During decoding, a pulse wider than the header high width pulses `frame_err_o` for one cycle and returns the receiver to searching, with no `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the bit rate |
| rst_ni | input | 1 | Active-low synchronous reset |
| line_i | input | 1 | Asynchronous biphase line |
| byte_o | output | 8 | Last assembled byte |
| byte_valid_o | output | 1 | One-cycle strobe, new byte on byte_o |
| done_o | output | 1 | One-cycle pulse when a packet times out |
| frame_err_o | output | 1 | One-cycle pulse on an over-wide data pulse |

## Verification
A line transition reaches the decoder two clock edges after it is driven. The byte strobe is registered one edge after that, so the strobe follows the final mid-bit transition of a byte by three cycles. The bench therefore does not predict the exact cycle of each byte. Instead it compares every strobe, in order, against a queue of expected bytes, sampling on the falling clock edge. The timeout is checked on both sides of its window: three cycles before twice the header width, `done_o` must not have pulsed, and ten cycles after that point it must have pulsed. Framing and ignored-stimulus checks are made after the line has been quiet for longer than any decision the receiver could still take.

// File: rtl/manch_rx_pkg.sv
package manch_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_HDR_LOW = 2'd1,
        ST_DATA    = 2'd2
    } rx_state_e;
endpackage

// File: rtl/manch_rx_sync.sv
// Two-stage synchronizer plus one delay stage used for transition detection.
module manch_rx_sync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic line_i,
    output logic edge_o,
    output logic prev_lvl_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.s1 = line_i;
        r_d.s2 = r_q.s1;
        r_d.s3 = r_q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign edge_o     = r_q.s2 ^ r_q.s3;
    assign prev_lvl_o = r_q.s3;
endmodule

// File: rtl/manch_rx_width.sv
// Counts cycles spent at the current level; restarts at one on each transition.
module manch_rx_width #(
    parameter int CNT_W = 12
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             edge_i,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (edge_i)                cnt_d = CNT_W'(1);
        else if (cnt_q == CNT_MAX) cnt_d = cnt_q;
        else                       cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= CNT_W'(1);
        else         cnt_q <= cnt_d;
    end

    assign width_o = cnt_q;

    // R3: pulse widths are never reported as zero
    nonzero_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        width_o != '0);
endmodule

// File: rtl/manch_rx.sv
module manch_rx #(
    parameter int CNT_W   = 12,
    parameter int MIN_HDR = 8
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       line_i,
    output logic [7:0] byte_o,
    output logic       byte_valid_o,
    output logic       done_o,
    output logic       frame_err_o
);
    import manch_rx_pkg::*;

    localparam logic [CNT_W-1:0] MIN_W = CNT_W'(MIN_HDR);

    typedef struct packed {
        rx_state_e        st;
        logic [CNT_W-1:0] hdr;
        logic             at_mid;
        logic [2:0]       nbit;
        logic [7:0]       sh;
        logic [7:0]       dout;
        logic             vld;
        logic             done;
        logic             err;
    } rx_t;

    logic             edg, prev_lvl;
    logic [CNT_W-1:0] width, thr;
    logic             take_bit;
    rx_t              r_d, r_q;

    manch_rx_sync u_sync (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .line_i     (line_i),
        .edge_o     (edg),
        .prev_lvl_o (prev_lvl)
    );

    manch_rx_width #(.CNT_W(CNT_W)) u_width (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .edge_i  (edg),
        .width_o (width)
    );

    assign thr      = r_q.hdr >> 1;
    assign take_bit = (width >= thr) || !r_q.at_mid;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        unique case (r_q.st)
            ST_HUNT: begin
                if (edg && prev_lvl && (width > MIN_W)) begin
                    r_d.hdr = width;
                    r_d.st  = ST_HDR_LOW;
                end
            end
            ST_HDR_LOW: begin
                if (edg) begin
                    if (width < thr) begin
                        r_d.st     = ST_DATA;
                        r_d.at_mid = 1'b1;
                        r_d.nbit   = '0;
                    end else begin
                        r_d.st = ST_HUNT;
                    end
                end else if (width >= thr) begin
                    r_d.st = ST_HUNT;
                end
            end
            ST_DATA: begin
                if (edg) begin
                    if (width > r_q.hdr) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_HUNT;
                    end else if (take_bit) begin
                        r_d.sh     = {r_q.sh[6:0], ~prev_lvl};
                        r_d.at_mid = 1'b1;
                        r_d.nbit   = r_q.nbit + 3'd1;
                        if (r_q.nbit == 3'd7) begin
                            r_d.dout = {r_q.sh[6:0], ~prev_lvl};
                            r_d.vld  = 1'b1;
                        end
                    end else begin
                        r_d.at_mid = 1'b0;
                    end
                end else if ({1'b0, width} >= {r_q.hdr, 1'b0}) begin
                    r_d.done = 1'b1;
                    r_d.st   = ST_HUNT;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            r_q    <= '0;
            r_q.st <= ST_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_o       = r_q.dout;
    assign byte_valid_o = r_q.vld;
    assign done_o       = r_q.done;
    assign frame_err_o  = r_q.err;

    // R5
    valid_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_o |=> !byte_valid_o);
    // R5
    valid_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        byte_valid_o |-> (r_q.nbit == 3'd0));
    // R7
    done_hunts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (r_q.st == ST_HUNT));
    // R8
    err_hunts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_err_o |-> (r_q.st == ST_HUNT && !done_o));
    // R2
    hdr_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == ST_DATA) |-> (r_q.hdr > MIN_W));
    // R7
    done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);
endmodule

// File: tb/manch_rx_tb.sv
`timescale 1ns/1ps
module manch_rx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line = 1'b0;
    logic [7:0] byte_o;
    logic       byte_valid_o, done_o, frame_err_o;

    always #10 clk = ~clk;

    manch_rx #(.CNT_W(12), .MIN_HDR(8)) u_dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .line_i       (line),
        .byte_o       (byte_o),
        .byte_valid_o (byte_valid_o),
        .done_o       (done_o),
        .frame_err_o  (frame_err_o)
    );

    int n_chk = 0, n_bad = 0;
    int n_vld = 0, n_done = 0, n_err = 0;
    logic [7:0] pkt [0:255];
    logic [7:0] expq [0:1023];
    int wr = 0, rd = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 R5: every strobe is compared in order with the expected byte queue
    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_valid_o) begin
                n_vld++;
                if (rd < wr) begin
                    check(byte_o == expq[rd], "R4/R5 byte", int'(byte_o), int'(expq[rd]));
                    rd++;
                end else begin
                    check(1'b0, "R2 unexpected byte", int'(byte_o), -1);
                end
            end
            if (done_o)      n_done++;
            if (frame_err_o) n_err++;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drives header, then biphase data as runs of half/full pulses.
    task automatic send_pkt(input int hh, input int hl, input int hw, input int fw,
                            input int n, input bit expect_bytes, input int tail);
        logic cur, lv;
        int   run;
        line = 1'b1; cyc(hh);
        line = 1'b0; cyc(hl);
        line = 1'b1;
        cur = 1'b1; run = 1;
        for (int k = 0; k < n; k++) begin
            if (expect_bytes) begin
                expq[wr] = pkt[k];
                wr++;
            end
            for (int b = 7; b >= 0; b--) begin
                for (int h = 0; h < 2; h++) begin
                    lv = (h == 0) ? ~pkt[k][b] : pkt[k][b];
                    if (lv == cur) run++;
                    else begin
                        cyc(run == 1 ? hw : fw);
                        cur = lv; line = lv; run = 1;
                    end
                end
            end
        end
        if (cur) begin
            cyc(tail);
            line = 1'b0;
        end
    endtask

    task automatic rate_pkt(input int hw, input int fw, input int hh, input int n, input string req);
        int d0;
        send_pkt(hh, hw, hw, fw, n, 1'b1, hw);
        d0 = n_done;
        cyc(2 * hh - 3);
        // R7: not before twice the header width
        check(n_done == d0, "R7 early done", n_done, d0);
        cyc(10);
        check(n_done == d0 + 1, "R7 timeout done", n_done, d0 + 1);
        check(rd == wr, req, rd, wr);
        cyc(20);
    endtask

    initial begin
        int v0, d0, e0;
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        // R1
        check(byte_o == 8'h00, "R1 byte", int'(byte_o), 0);
        check({byte_valid_o, done_o, frame_err_o} == 3'b000, "R1 strobes",
              int'({byte_valid_o, done_o, frame_err_o}), 0);
        cyc(20);

        // R4 R5: every byte value at half width 6
        for (int k = 0; k < 256; k++) pkt[k] = 8'(k);
        rate_pkt(6, 12, 18, 256, "R5 all bytes");

        // R6: other rates learned from their own headers
        for (int k = 0; k < 32; k++) pkt[k] = 8'((k * 37 + 11) ^ 8'h5A);
        rate_pkt(4, 8, 12, 32, "R6 fast rate");
        for (int k = 0; k < 32; k++) pkt[k] = 8'(k * 73 + 200);
        rate_pkt(9, 18, 27, 32, "R6 slow rate");

        // R3: threshold 9, half pulses 8, full pulses 9
        for (int k = 0; k < 16; k++) pkt[k] = 8'(k * 29 + 3);
        send_pkt(18, 6, 8, 9, 16, 1'b1, 8);
        cyc(50);
        check(rd == wr, "R3 boundary widths", rd, wr);

        // R8: over-wide pulse after one byte
        pkt[0] = 8'hA5;
        d0 = n_done; e0 = n_err;
        send_pkt(18, 6, 6, 12, 1, 1'b1, 25);
        cyc(60);
        check(n_err == e0 + 1, "R8 frame error", n_err, e0 + 1);
        check(n_done == d0, "R8 no done", n_done, d0);
        check(rd == wr, "R8 byte before error", rd, wr);

        // R2: header high too short
        for (int k = 0; k < 8; k++) pkt[k] = 8'(k * 51 + 7);
        v0 = n_vld; d0 = n_done;
        send_pkt(8, 3, 3, 6, 8, 1'b0, 3);
        cyc(60);
        check(n_vld == v0, "R2 short header ignored", n_vld, v0);
        check(n_done == d0, "R2 short header no done", n_done, d0);

        // R2: header low too long
        send_pkt(18, 12, 4, 8, 8, 1'b0, 4);
        cyc(60);
        check(n_vld == v0, "R2 long low ignored", n_vld, v0);
        check(n_done == d0, "R2 long low no done", n_done, d0);

        // R6: decoding recovers after rejected headers
        for (int k = 0; k < 8; k++) pkt[k] = 8'(255 - k * 17);
        rate_pkt(5, 10, 15, 8, "R6 recovery");

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule